// File: doc/BRIEF.md
# Hybrid Static/Dynamic Branch Predictor

This block guesses, for every conditional branch the front end fetches, whether the branch will be taken and from which address fetching should continue. It keeps a direct-mapped table of 256 entries. Each entry holds a valid flag, an address tag, a two-bit saturating counter and the last known target, so one read gives both the direction history and the target. A branch that finds its entry follows the counter. A branch with no entry is predicted from its displacement sign: backward branches are guessed taken and forward branches not taken.

The lookup side is combinational: the fetch stage presents the branch PC, the decoded direction of the displacement and the decoded target, and it receives hit, taken and the next fetch address in the same cycle. Later the execute stage returns the resolved outcome and target, along with the prediction that was made for that branch. The block then trains the table. When the guess was wrong, it raises a one-cycle redirect one clock later and supplies the corrected fetch address. Flushing the pipeline is left to the surrounding logic.

Top module: `bp_hybrid_predictor`

## Requirements
- R1: A synchronous active-high reset invalidates every entry, so the first lookup after reset misses (`pr_hit`=0). Reset also clears `redirect`.
- R2: On a lookup miss, `pr_taken` equals `lk_backward`, where 1 means the decoded target lies below the branch PC.
- R3: On a lookup hit, `pr_taken` is 1 when the entry's counter is 2 or 3 and 0 when it is 0 or 1; `lk_backward` is then ignored.
- R4: `pr_target` is the stored target when a hit predicts taken, `lk_target` when a miss predicts taken, and `lk_pc`+4 when the prediction is not taken.
- R5: A resolved branch that misses the table allocates an entry only when it was taken. The new entry has counter 2 and the resolved target. A not-taken miss leaves the table unchanged.
- R6: On a hit, a taken outcome increments the counter, saturating at 3, and a not-taken outcome decrements it, saturating at 0.
- R7: On a hit with a taken outcome, the stored target is replaced by the resolved target.
- R8: The table index is PC bits [9:2] and the tag is PC bits [31:10]. A PC whose index matches but whose tag differs misses, and if it is allocated it replaces the older entry.
- R9: When a lookup and an update use the same entry in the same cycle, the lookup sees the contents from before the update.
- R10: One cycle after an update whose resolved direction differs from the predicted direction, or whose taken target differs from the predicted target, `redirect` is 1. `redirect_pc` is then the resolved target for a taken branch, or `up_pc`+4 for a not-taken branch.
- R11: `redirect` is 0 in the cycle after a correctly predicted update and in the cycle after a cycle with no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_pc | input | 32 | Branch PC for lookup |
| lk_backward | input | 1 | Decoded displacement is negative |
| lk_target | input | 32 | Decoded branch target |
| pr_hit | output | 1 | Lookup found a matching entry |
| pr_taken | output | 1 | Predicted direction |
| pr_target | output | 32 | Predicted next fetch address |
| up_valid | input | 1 | Resolved branch valid |
| up_pc | input | 32 | PC of the resolved branch |
| up_taken | input | 1 | Resolved direction |
| up_target | input | 32 | Resolved target |
| up_pred_taken | input | 1 | Direction that was predicted |
| up_pred_target | input | 32 | Fetch address that was predicted |
| redirect | output | 1 | Misprediction: refetch request |
| redirect_pc | output | 32 | Corrected fetch address |

## Verification
One branch is trained through its whole counter range. Runs of taken and not-taken outcomes show that the direction comes from the counter and that both ends saturate, and a lookup with the opposite displacement sign shows that the static rule is set aside on a hit. Cold lookups with backward and forward displacements separate the static fallback from a default of not taken. A second PC that shares the first one's index but has a different tag shows that aliasing misses and that the older entry is evicted. Updates with a wrong direction and with a right direction but a wrong target separate the two redirect causes, and lookups in the same cycle as an update show that the lookup reads the contents from before the update.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int PC_W    = 32;
    localparam int IDX_W   = 8;
    localparam int ENTRIES = 1 << IDX_W;
    localparam int ILEN    = 4;
    localparam int LSB     = 2;
    localparam int TAG_W   = PC_W - IDX_W - LSB;
    localparam int CTR_W   = 2;

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [CTR_W-1:0] ctr_t;

    localparam ctr_t CTR_MAX   = '1;
    localparam ctr_t CTR_ALLOC = ctr_t'(1 << (CTR_W - 1));

    typedef struct packed {
        tag_t tag;
        ctr_t ctr;
        pc_t  target;
    } entry_t;

    function automatic idx_t idx_of(pc_t pc);
        return pc[LSB +: IDX_W];
    endfunction

    function automatic tag_t tag_of(pc_t pc);
        return pc[PC_W-1 -: TAG_W];
    endfunction

    function automatic logic ctr_says_taken(ctr_t c);
        return c[CTR_W-1];
    endfunction

    function automatic ctr_t ctr_step(ctr_t c, logic taken);
        if (taken)
            return (c == CTR_MAX) ? c : c + ctr_t'(1);
        return (c == '0) ? c : c - ctr_t'(1);
    endfunction
endpackage

// File: rtl/bp_table.sv
module bp_table
    import bp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  idx_t   rd_a_idx,
    output logic   rd_a_vld,
    output entry_t rd_a_ent,
    input  idx_t   rd_b_idx,
    output logic   rd_b_vld,
    output entry_t rd_b_ent,
    input  logic   wr_en,
    input  idx_t   wr_idx,
    input  entry_t wr_ent
);
    logic [ENTRIES-1:0] vld_q;
    entry_t             mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst)
            vld_q <= '0;
        else if (wr_en)
            vld_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[wr_idx] <= wr_ent;
    end

    assign rd_a_vld = vld_q[rd_a_idx];
    assign rd_a_ent = mem_q[rd_a_idx];
    assign rd_b_vld = vld_q[rd_b_idx];
    assign rd_b_ent = mem_q[rd_b_idx];
endmodule

// File: rtl/bp_lookup.sv
module bp_lookup
    import bp_pkg::*;
(
    input  pc_t    lk_pc,
    input  logic   lk_backward,
    input  pc_t    lk_target,
    input  logic   ent_vld,
    input  entry_t ent,
    output logic   hit,
    output logic   taken,
    output pc_t    target
);
    always_comb begin
        hit   = ent_vld && (ent.tag == tag_of(lk_pc));
        taken = hit ? ctr_says_taken(ent.ctr) : lk_backward;
        if (!taken)
            target = lk_pc + pc_t'(ILEN);
        else if (hit)
            target = ent.target;
        else
            target = lk_target;
    end
endmodule

// File: rtl/bp_resolve.sv
module bp_resolve
    import bp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   up_valid,
    input  pc_t    up_pc,
    input  logic   up_taken,
    input  pc_t    up_target,
    input  logic   up_pred_taken,
    input  pc_t    up_pred_target,
    input  logic   ent_vld,
    input  entry_t ent,
    output logic   wr_en,
    output idx_t   wr_idx,
    output entry_t wr_ent,
    output logic   redirect,
    output pc_t    redirect_pc
);
    logic hit;
    logic mispredict;

    always_comb begin
        hit        = ent_vld && (ent.tag == tag_of(up_pc));
        wr_idx     = idx_of(up_pc);
        wr_en      = up_valid && (hit || up_taken);
        wr_ent.tag = tag_of(up_pc);
        if (hit) begin
            wr_ent.ctr    = ctr_step(ent.ctr, up_taken);
            wr_ent.target = up_taken ? up_target : ent.target;
        end else begin
            wr_ent.ctr    = CTR_ALLOC;
            wr_ent.target = up_target;
        end
        mispredict = (up_taken != up_pred_taken)
                   || (up_taken && (up_target != up_pred_target));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect    <= 1'b0;
            redirect_pc <= '0;
        end else begin
            redirect    <= up_valid && mispredict;
            redirect_pc <= up_taken ? up_target : up_pc + pc_t'(ILEN);
        end
    end
endmodule

// File: rtl/bp_hybrid_predictor.sv
module bp_hybrid_predictor
    import bp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            lk_backward,
    input  logic [PC_W-1:0] lk_target,
    output logic            pr_hit,
    output logic            pr_taken,
    output logic [PC_W-1:0] pr_target,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic [PC_W-1:0] up_target,
    input  logic            up_pred_taken,
    input  logic [PC_W-1:0] up_pred_target,
    output logic            redirect,
    output logic [PC_W-1:0] redirect_pc
);
    logic   lk_vld, upd_vld, wr_en;
    entry_t lk_ent, upd_ent, wr_ent;
    idx_t   wr_idx;
    logic   hit_raw;

    bp_table u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (idx_of(lk_pc)),
        .rd_a_vld (lk_vld),
        .rd_a_ent (lk_ent),
        .rd_b_idx (idx_of(up_pc)),
        .rd_b_vld (upd_vld),
        .rd_b_ent (upd_ent),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_ent   (wr_ent)
    );

    bp_lookup u_lookup (
        .lk_pc       (lk_pc),
        .lk_backward (lk_backward),
        .lk_target   (lk_target),
        .ent_vld     (lk_vld),
        .ent         (lk_ent),
        .hit         (hit_raw),
        .taken       (pr_taken),
        .target      (pr_target)
    );

    assign pr_hit = lk_valid && hit_raw;

    bp_resolve u_resolve (
        .clk            (clk),
        .rst            (rst),
        .up_valid       (up_valid),
        .up_pc          (up_pc),
        .up_taken       (up_taken),
        .up_target      (up_target),
        .up_pred_taken  (up_pred_taken),
        .up_pred_target (up_pred_target),
        .ent_vld        (upd_vld),
        .ent            (upd_ent),
        .wr_en          (wr_en),
        .wr_idx         (wr_idx),
        .wr_ent         (wr_ent),
        .redirect       (redirect),
        .redirect_pc    (redirect_pc)
    );
endmodule

// File: rtl/bp_hybrid_predictor_chk.sv
module bp_hybrid_predictor_chk (
    input logic        clk,
    input logic        rst,
    input logic        lk_valid,
    input logic [31:0] lk_pc,
    input logic        lk_backward,
    input logic        pr_hit,
    input logic        pr_taken,
    input logic [31:0] pr_target,
    input logic        up_valid,
    input logic [31:0] up_pc,
    input logic        up_taken,
    input logic [31:0] up_target,
    input logic        up_pred_taken,
    input logic [31:0] up_pred_target,
    input logic        redirect,
    input logic [31:0] redirect_pc
);
    AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        $past(rst) && lk_valid |-> !pr_hit); // R1
    AST_STATIC_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        lk_valid && !pr_hit |-> pr_taken == lk_backward); // R2
    AST_FALLTHRU_TARGET: assert property (@(posedge clk) disable iff (rst)
        lk_valid && !pr_taken |-> pr_target == lk_pc + 32'd4); // R4
    AST_DIR_MISS_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        up_valid && (up_taken != up_pred_taken) |=> redirect); // R10
    AST_TGT_MISS_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        up_valid && up_taken && up_pred_taken && (up_target != up_pred_target)
        |=> redirect && redirect_pc == $past(up_target)); // R10
    AST_CORRECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        up_valid && (up_taken == up_pred_taken)
        && (!up_taken || up_target == up_pred_target) |=> !redirect); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> !redirect); // R11
endmodule

bind bp_hybrid_predictor bp_hybrid_predictor_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .lk_valid       (lk_valid),
    .lk_pc          (lk_pc),
    .lk_backward    (lk_backward),
    .pr_hit         (pr_hit),
    .pr_taken       (pr_taken),
    .pr_target      (pr_target),
    .up_valid       (up_valid),
    .up_pc          (up_pc),
    .up_taken       (up_taken),
    .up_target      (up_target),
    .up_pred_taken  (up_pred_taken),
    .up_pred_target (up_pred_target),
    .redirect       (redirect),
    .redirect_pc    (redirect_pc)
);

// File: tb/bp_hybrid_predictor_tb.sv
module bp_hybrid_predictor_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0, lk_backward = 1'b0;
    logic [31:0] lk_pc = '0, lk_target = '0;
    logic        pr_hit, pr_taken;
    logic [31:0] pr_target;
    logic        up_valid = 1'b0, up_taken = 1'b0, up_pred_taken = 1'b0;
    logic [31:0] up_pc = '0, up_target = '0, up_pred_target = '0;
    logic        redirect;
    logic [31:0] redirect_pc;
    int          errors = 0;
    int          checks = 0;

    always #4 clk = ~clk;

    bp_hybrid_predictor dut_i (.*);

    typedef struct packed {
        logic        uv;   logic [31:0] upc;  logic utk;  logic [31:0] utg;
        logic        uptk; logic [31:0] uptg; logic xrd;  logic [31:0] xrpc;
        logic [31:0] lpc;  logic lbk;  logic [31:0] ltg;
        logic        xhit; logic xtk;  logic [31:0] xtg;
    } vec_t;

    localparam int NV = 15;
    // Branch A = 0x1040 (index 0x10); B = 0x1440 shares the index, different tag.
    localparam vec_t VECS [NV] = '{
        // 0 R2 R4: cold backward lookup, static taken to decoded target
        '{1'b0,32'h0,1'b0,32'h0,1'b0,32'h0,1'b0,32'h0, 32'h1040,1'b1,32'h1000, 1'b0,1'b1,32'h1000},
        // 1 R2 R4: cold forward lookup, not taken, fall through
        '{1'b0,32'h0,1'b0,32'h0,1'b0,32'h0,1'b0,32'h0, 32'h1040,1'b0,32'h1080, 1'b0,1'b0,32'h1044},
        // 2 R5 R11: not-taken miss allocates nothing, correct guess is quiet
        '{1'b1,32'h1040,1'b0,32'h1044,1'b0,32'h1044,1'b0,32'h0, 32'h1040,1'b1,32'h1000, 1'b0,1'b1,32'h1000},
        // 3 R5 R10: taken miss allocates ctr=2; forward lookup now hit taken
        '{1'b1,32'h1040,1'b1,32'h1000,1'b0,32'h1044,1'b1,32'h1000, 32'h1040,1'b0,32'h1080, 1'b1,1'b1,32'h1000},
        // 4 R6 R11: ctr 2->3
        '{1'b1,32'h1040,1'b1,32'h1000,1'b1,32'h1000,1'b0,32'h0, 32'h1040,1'b0,32'h1080, 1'b1,1'b1,32'h1000},
        // 5 R6: saturate at 3
        '{1'b1,32'h1040,1'b1,32'h1000,1'b1,32'h1000,1'b0,32'h0, 32'h1040,1'b0,32'h1080, 1'b1,1'b1,32'h1000},
        // 6 R6 R10: ctr 3->2, still taken; redirect to fall through
        '{1'b1,32'h1040,1'b0,32'h1000,1'b1,32'h1000,1'b1,32'h1044, 32'h1040,1'b0,32'h1080, 1'b1,1'b1,32'h1000},
        // 7 R3: ctr 2->1, backward lookup predicted not taken
        '{1'b1,32'h1040,1'b0,32'h1000,1'b1,32'h1000,1'b1,32'h1044, 32'h1040,1'b1,32'h1000, 1'b1,1'b0,32'h1044},
        // 8 R6: ctr 1->0
        '{1'b1,32'h1040,1'b0,32'h1000,1'b0,32'h1044,1'b0,32'h0, 32'h1040,1'b1,32'h1000, 1'b1,1'b0,32'h1044},
        // 9 R6: saturate at 0
        '{1'b1,32'h1040,1'b0,32'h1000,1'b0,32'h1044,1'b0,32'h0, 32'h1040,1'b1,32'h1000, 1'b1,1'b0,32'h1044},
        // 10 R7 R10: taken to new target, ctr 0->1
        '{1'b1,32'h1040,1'b1,32'h2000,1'b0,32'h1044,1'b1,32'h2000, 32'h1040,1'b0,32'h1080, 1'b1,1'b0,32'h1044},
        // 11 R7 R10: right direction, wrong target; ctr 1->2, new target used
        '{1'b1,32'h1040,1'b1,32'h2000,1'b1,32'h1000,1'b1,32'h2000, 32'h1040,1'b0,32'h1080, 1'b1,1'b1,32'h2000},
        // 12 R8: alias B misses
        '{1'b0,32'h0,1'b0,32'h0,1'b0,32'h0,1'b0,32'h0, 32'h1440,1'b0,32'h1480, 1'b0,1'b0,32'h1444},
        // 13 R8: B allocated, evicts A
        '{1'b1,32'h1440,1'b1,32'h1400,1'b0,32'h1444,1'b1,32'h1400, 32'h1040,1'b0,32'h1080, 1'b0,1'b0,32'h1044},
        // 14 R8: B hits
        '{1'b0,32'h0,1'b0,32'h0,1'b0,32'h0,1'b0,32'h0, 32'h1440,1'b0,32'h1480, 1'b1,1'b1,32'h1400}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lookup(logic [31:0] pc, logic bk, logic [31:0] tg);
        lk_valid = 1'b1; lk_pc = pc; lk_backward = bk; lk_target = tg;
    endtask

    task automatic update(logic [31:0] pc, logic tk, logic [31:0] tg,
                          logic ptk, logic [31:0] ptg);
        up_valid = 1'b1; up_pc = pc; up_taken = tk; up_target = tg;
        up_pred_taken = ptk; up_pred_target = ptg;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        lookup(32'h1040, 1'b1, 32'h1000);
        #1;
        check("R1 reset lookup miss", {31'b0, pr_hit}, 32'd0);
        check("R1 reset redirect clear", {31'b0, redirect}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            lk_valid = 1'b0;
            up_valid = VECS[i].uv;
            if (VECS[i].uv)
                update(VECS[i].upc, VECS[i].utk, VECS[i].utg, VECS[i].uptk, VECS[i].uptg);
            @(negedge clk);
            up_valid = 1'b0;
            lookup(VECS[i].lpc, VECS[i].lbk, VECS[i].ltg);
            #1;
            check($sformatf("R10/R11 vec%0d redirect", i), {31'b0, redirect}, {31'b0, VECS[i].xrd});
            if (VECS[i].xrd)
                check($sformatf("R10 vec%0d redirect_pc", i), redirect_pc, VECS[i].xrpc);
            check($sformatf("R3/R8 vec%0d hit", i), {31'b0, pr_hit}, {31'b0, VECS[i].xhit});
            check($sformatf("R2/R3 vec%0d taken", i), {31'b0, pr_taken}, {31'b0, VECS[i].xtk});
            check($sformatf("R4 vec%0d target", i), pr_target, VECS[i].xtg);
        end

        // R9: same-cycle lookup and update on hit entry B (ctr 2 -> 1)
        @(negedge clk);
        update(32'h1440, 1'b0, 32'h1400, 1'b1, 32'h1400);
        lookup(32'h1440, 1'b0, 32'h1480);
        #1;
        check("R9 pre-update taken", {31'b0, pr_taken}, 32'd1);
        check("R9 pre-update target", pr_target, 32'h1400);
        @(negedge clk);
        up_valid = 1'b0;
        #1;
        check("R10 not-taken redirect", {31'b0, redirect}, 32'd1);
        check("R10 not-taken redirect_pc", redirect_pc, 32'h1444);
        check("R6 post-update not taken", {31'b0, pr_taken}, 32'd0);

        // R9: same-cycle allocation of C, lookup sees the miss
        @(negedge clk);
        update(32'h2080, 1'b1, 32'h2000, 1'b0, 32'h2084);
        lookup(32'h2080, 1'b0, 32'h2100);
        #1;
        check("R9 pre-alloc miss", {31'b0, pr_hit}, 32'd0);
        check("R9 pre-alloc target", pr_target, 32'h2084);
        @(negedge clk);
        up_valid = 1'b0;
        #1;
        check("R5 alloc hit", {31'b0, pr_hit}, 32'd1);
        check("R5 alloc taken target", pr_target, 32'h2000);

        // R1: reset mid-run with a mispredict pending
        @(negedge clk);
        update(32'h2080, 1'b0, 32'h2000, 1'b1, 32'h2000);
        rst = 1'b1;
        @(negedge clk);
        up_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        lookup(32'h2080, 1'b0, 32'h2100);
        #1;
        check("R1 redirect cleared", {31'b0, redirect}, 32'd0);
        check("R1 entry C invalid", {31'b0, pr_hit}, 32'd0);
        check("R2 static forward after reset", {31'b0, pr_taken}, 32'd0);
        lookup(32'h1440, 1'b1, 32'h1400);
        #1;
        check("R1 entry B invalid", {31'b0, pr_hit}, 32'd0);
        check("R2 static backward after reset", {31'b0, pr_taken}, 32'd1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule